// File: doc/BRIEF.md
# Masked interrupt request aggregator

This block gathers one-cycle event pulses from nine peripheral sources into a single processor interrupt. The sources are disk transfer complete, disk change, serial byte received, serial byte transmitted, four audio sample-finished events and graphics copy complete. Each pulse latches its own flag in a request register, so the processor never has to poll a peripheral. A separate enable register masks which flags may raise the interrupt. Bit 14 of the enable register is a master switch for all of them.

Software reads both registers over a small register bus and changes them with a guarded set/clear convention. Bit 15 of a write picks the direction: 1 sets each bit written as 1 in bits 14:0, and 0 clears each such bit. A write of plain data with bit 15 at 0 and no ones below it therefore changes nothing. The block does no arbitration between sources. The interrupt appears as a fixed level 2 on a 3-bit priority bus. The service routine reads the request register to find every pending event.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, both registers read as 0x0000 and `irq_level` is 0.
- R2: A 1 on `ev_pulse[i]` sets request bit i. The bit mapping is: 0 disk transfer done, 1 disk change, 2 serial receive, 3 serial transmit, 4 to 7 audio channels 0 to 3, 8 graphics copy done. Once set, the bit stays set until software clears it.
- R3: A write to the request register (`bus_addr`=0) with bit 15 = 1 sets every request bit given as 1 in bits 14:0 and leaves the other bits unchanged.
- R4: A write to the request register with bit 15 = 0 clears every request bit given as 1 in bits 14:0. Bits given as 0 are unchanged, so writing 0x0000 alters nothing.
- R5: The enable register (`bus_addr`=1) follows the same set/clear convention as R3 and R4.
- R6: `irq_level` is 2 when enable bit 14 is 1 and at least one bit in 13:0 is 1 in both the request and enable registers. Otherwise `irq_level` is 0. It changes one clock after the register update that causes the change.
- R7: A write to the enable register never alters the request register.
- R8: When a hardware pulse and a software clear hit the same request bit in the same cycle, the bit ends up set.
- R9: A read (`bus_rd`=1) places the addressed register on `bus_rdata` one clock later. Bit 15 of that value is always 0. `bus_rdata` holds its value between reads.
- R10: Several requests can be pending at once, and all of them are visible in a read. `irq_level` stays at 2 until the last enabled pending request has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 9 | One-cycle event pulses from the peripheral sources |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register select: 0 selects request, 1 selects enable |
| bus_wdata | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| bus_rdata | output | 16 | Registered read data |
| irq_level | output | 3 | Processor priority level: 2 when an interrupt is active, otherwise 0 |

## Verification
The collision that matters is a hardware event pulse on a request bit in the same cycle as a software clear of that same bit. The bench provokes it by driving the pulse and the clearing write together on one clock. It then judges the result by reading the request register, which must still show the bit set, and by checking that the interrupt level rises. A second overlap is a read in the same cycle as an update. There, the bench's cycle model expects the value from before the update, and it compares both outputs against that model on every clock.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W     = 16;
  localparam int FLAG_W     = DATA_W - 1;
  localparam int MASTER_BIT = DATA_W - 2;
  localparam int NUM_SRC    = 9;
  localparam int LVL_W      = 3;
  localparam logic [LVL_W-1:0] IRQ_LEVEL = 3'd2;
  localparam logic ADDR_REQ = 1'b0;
  localparam logic ADDR_ENA = 1'b1;
endpackage

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
  parameter int DATA_W = 16,
  localparam int FLAG_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [FLAG_W-1:0] hw_set,
  output logic [FLAG_W-1:0] q
);
  logic [FLAG_W-1:0] sw_mask;
  logic [FLAG_W-1:0] after_sw;

  assign sw_mask = wdata[FLAG_W-1:0];

  always_comb begin
    after_sw = q;
    if (wr_en) begin
      if (wdata[DATA_W-1]) after_sw = q | sw_mask;
      else                 after_sw = q & ~sw_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= after_sw | hw_set;
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_chk
    a_r2_pulse_sets: assert property (@(posedge clk) disable iff (rst)
      hw_set[i] |=> q[i]);
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
      (hw_set[i] && wr_en && !wdata[DATA_W-1] && wdata[i]) |=> q[i]);
    a_r4_clear_bit: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wdata[DATA_W-1] && wdata[i] && !hw_set[i]) |=> !q[i]);
    a_r3_set_bit: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wdata[DATA_W-1] && wdata[i]) |=> q[i]);
  end
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc #(
  parameter int FLAG_W = 15,
  parameter int MASTER_BIT = 14,
  parameter int LVL_W = 3,
  parameter logic [LVL_W-1:0] LEVEL = 3'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] req,
  input  logic [FLAG_W-1:0] ena,
  output logic [LVL_W-1:0]  irq_level
);
  logic any_hit;

  assign any_hit = ena[MASTER_BIT] && (|(req[MASTER_BIT-1:0] & ena[MASTER_BIT-1:0]));

  always_ff @(posedge clk) begin
    if (rst)          irq_level <= '0;
    else if (any_hit) irq_level <= LEVEL;
    else              irq_level <= '0;
  end

  a_r6_level_code: assert property (@(posedge clk) disable iff (rst)
    (irq_level == '0) || (irq_level == LEVEL));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] ev_pulse,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [LVL_W-1:0]   irq_level
);
  logic [FLAG_W-1:0] req_q;
  logic [FLAG_W-1:0] ena_q;
  logic [FLAG_W-1:0] req_hw;
  logic              req_wr;
  logic              ena_wr;

  assign req_hw = {{(FLAG_W-NUM_SRC){1'b0}}, ev_pulse};
  assign req_wr = bus_wr && (bus_addr == ADDR_REQ);
  assign ena_wr = bus_wr && (bus_addr == ADDR_ENA);

  irq_setclr_reg #(.DATA_W(DATA_W)) u_req (
    .clk(clk), .rst(rst), .wr_en(req_wr), .wdata(bus_wdata),
    .hw_set(req_hw), .q(req_q)
  );

  irq_setclr_reg #(.DATA_W(DATA_W)) u_ena (
    .clk(clk), .rst(rst), .wr_en(ena_wr), .wdata(bus_wdata),
    .hw_set('0), .q(ena_q)
  );

  irq_level_enc #(
    .FLAG_W(FLAG_W), .MASTER_BIT(MASTER_BIT), .LVL_W(LVL_W), .LEVEL(IRQ_LEVEL)
  ) u_lvl (
    .clk(clk), .rst(rst), .req(req_q), .ena(ena_q), .irq_level(irq_level)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      if (bus_addr == ADDR_ENA) bus_rdata <= {1'b0, ena_q};
      else                      bus_rdata <= {1'b0, req_q};
    end
  end

  a_r7_ena_write_keeps_req: assert property (@(posedge clk) disable iff (rst)
    (ena_wr && ev_pulse == '0 && !req_wr) |=> $stable(req_q));
  a_r6_master_off: assert property (@(posedge clk) disable iff (rst)
    !ena_q[MASTER_BIT] |=> (irq_level == '0));
  a_r9_msb_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rdata[DATA_W-1]);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  ev_pulse = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  irq_level;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_level(irq_level)
  );

  // behavioural cycle model
  int mreq = 0, mena = 0, mlvl = 0, mrd = 0;
  always @(posedge clk) begin
    int nreq, nena, m;
    if (rst) begin
      mreq = 0; mena = 0; mlvl = 0; mrd = 0;
    end else begin
      nreq = mreq; nena = mena;
      if (bus_rd) mrd = bus_addr ? mena : mreq;
      mlvl = (((mena >> 14) & 1) != 0 && (mreq & mena & 'h3FFF) != 0) ? 2 : 0;
      if (bus_wr) begin
        m = int'(bus_wdata) & 'h7FFF;
        if (!bus_addr) nreq = bus_wdata[15] ? (nreq | m) : (nreq & ~m);
        else           nena = bus_wdata[15] ? (nena | m) : (nena & ~m);
      end
      nreq = nreq | int'(ev_pulse);
      mreq = nreq; mena = nena;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (int'(irq_level) != mlvl) begin
        fails++;
        $display("FAIL R6 model level: actual %0d expected %0d", irq_level, mlvl);
      end
      checks++;
      if (int'(bus_rdata) != mrd) begin
        fails++;
        $display("FAIL R9 model rdata: actual %h expected %h", bus_rdata, mrd[15:0]);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d, input logic [8:0] ev = '0);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; ev_pulse = ev;
    @(negedge clk);
    bus_wr = 1'b0; ev_pulse = '0;
  endtask

  task automatic pulse(input logic [8:0] ev);
    ev_pulse = ev;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  task automatic rd(input logic a, output int v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = int'(bus_rdata);
  endtask

  task automatic finish_up;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd(1'b0, v); check("R1 request after reset", v, 0);
    rd(1'b1, v); check("R1 enable after reset", v, 0);
    check("R1 level after reset", int'(irq_level), 0);

    for (int i = 0; i < 9; i++) begin
      pulse(9'(1 << i));
      rd(1'b0, v); check("R2 pulse accumulates", v, (1 << (i + 1)) - 1);
    end
    check("R6 no enable no level", int'(irq_level), 0);

    wr(1'b1, 16'h8001); @(negedge clk);
    check("R6 master off", int'(irq_level), 0);
    wr(1'b1, 16'hC000);
    check("R6 level one cycle late", int'(irq_level), 0);
    @(negedge clk);
    check("R6 level raised", int'(irq_level), 2);
    rd(1'b1, v); check("R5 enable set", v, 'h4001);
    rd(1'b0, v); check("R7 enable write keeps request", v, 'h1FF);

    wr(1'b0, 16'h0001); @(negedge clk);
    check("R6 level drops after clear", int'(irq_level), 0);
    rd(1'b0, v); check("R4 clear bit0", v, 'h1FE);
    wr(1'b0, 16'h0000);
    rd(1'b0, v); check("R4 zero write no change", v, 'h1FE);
    wr(1'b0, 16'h9000);
    rd(1'b0, v); check("R3 software set bit12", v, 'h11FE);

    wr(1'b1, 16'h8006); @(negedge clk);
    check("R10 two pending level", int'(irq_level), 2);
    wr(1'b0, 16'h0002); @(negedge clk);
    check("R10 one left still level", int'(irq_level), 2);
    wr(1'b0, 16'h0004); @(negedge clk);
    check("R10 last cleared level off", int'(irq_level), 0);
    rd(1'b0, v); check("R10 remaining pending visible", v, 'h11F8);

    wr(1'b0, 16'h0002, 9'h002); @(negedge clk);
    check("R8 collision raises level", int'(irq_level), 2);
    rd(1'b0, v); check("R8 set wins over clear", v, 'h11FA);

    wr(1'b1, 16'hFFFF);
    rd(1'b1, v); check("R9 msb reads zero", v, 'h7FFF);
    wr(1'b1, 16'h4000); @(negedge clk);
    check("R5 master cleared level", int'(irq_level), 0);
    rd(1'b1, v); check("R5 enable clear", v, 'h3FFF);
    rd(1'b0, v); check("R7 request unchanged by enables", v, 'h11FA);

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule